// File: doc/BRIEF.md
# UART Register Bus Master

This block moves bytes between a command controller and a memory-mapped UART peripheral. It reaches the peripheral over an AXI4-Lite master port. Each access is a single transaction with one address and one 32-bit data word, and only the low byte of that word carries meaning. The block never lets the peripheral FIFOs overflow or underflow. It reads the peripheral's status word before every data access and acts only on what that read reports.

The controller side has two valid/ready byte streams. On the transmit side, `tx_valid`/`tx_ready` feed a one-byte buffer. `tx_ready` is low while that buffer holds a byte that has not yet been written out, which is how back-pressure from a full UART transmit FIFO reaches the controller. On the receive side, `rx_valid`/`rx_ready` present bytes fetched from the peripheral. A presented byte stays stable until the controller accepts it. No further byte is fetched while one is waiting, so a slow controller simply leaves data in the UART receive FIFO.

With nothing else to do, the block polls status continuously. When a status read shows both receive data and room to transmit, it serves the receive side first. Any error response on the bus sets a sticky flag that clears only on reset. The failed access is never repeated.

Top module: `uart_lite_master`

## Requirements
- R1: While `rst_n` is low and directly after its release, `awvalid`, `wvalid`, `arvalid`, `rx_valid` and `err_flag` are 0 and `tx_ready` is 1.
- R2: A write raises `awvalid` and `wvalid` in the same cycle. Each is held, with `awaddr`/`wdata` stable, until its own ready is seen. `bready` is then held until `bvalid`, and no other access begins before that response.
- R3: A read holds `arvalid`, with `araddr` stable, until `arready`, then takes `rdata` with `rready`. A read and a write are never requested together, and at most one transaction is outstanding.
- R4: Register offsets are 0x0 receive data, 0x4 transmit data, 0x8 status. Writes go only to 0x4, and reads come only from 0x0 or 0x8.
- R5: A transmit byte is sent as `wdata = {24'h0, byte}` with `wstrb = 4'b0001`.
- R6: A transmit write starts only when the most recent completed read was a status read with an OKAY response and status bit 3 (transmit FIFO full) equal to 0.
- R7: A receive-data read starts only when the most recent completed read was a status read with an OKAY response and status bit 0 (receive data valid) equal to 1, and no received byte is waiting at `rx_valid`.
- R8: `rx_data` is `rdata[7:0]` of a successful receive-data read. `rx_valid` and `rx_data` stay unchanged until `rx_valid && rx_ready`.
- R9: `tx_ready` is 1 exactly when the transmit buffer is empty, and a byte is taken on `tx_valid && tx_ready`.
- R10: A nonzero `bresp` or `rresp` sets `err_flag`, which stays 1 until reset. The failed access is not retried: a failed write drops its byte and a failed receive-data read yields no byte.
- R11: If one status read reports both receive data valid and transmit not full, while a transmit byte is buffered and no receive byte is waiting, the receive-data read is issued before the transmit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Controller offers a byte to transmit |
| tx_ready | output | 1 | Transmit buffer empty, byte accepted |
| tx_data | input | 8 | Byte to transmit |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Controller accepts received byte |
| rx_data | output | 8 | Received byte |
| err_flag | output | 1 | Sticky bus error indication |
| awaddr | output | ADDR_W | Write address |
| awprot | output | 3 | Write protection type, always 0 |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Write byte strobes |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bresp | input | 2 | Write response |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| araddr | output | ADDR_W | Read address |
| arprot | output | 3 | Read protection type, always 0 |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | DATA_W | Read data |
| rresp | input | 2 | Read response |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |

## Verification
The transmit path is driven with a set of bytes that includes all-zeros, all-ones and single-bit patterns. The peripheral model delays address-ready and data-ready by different amounts for each byte, which separates correct per-channel holding from logic that assumes both handshakes land together. The model reports the transmit FIFO full for a long stretch, which shows that writes are gated by status and not by timing. A received byte left unaccepted, with a second byte queued behind it, shows whether the holding rule stops further fetches. Receive data and free transmit space are made to appear on the same cycle to expose the service order. Error responses on a write and on a receive read check the sticky flag, the absence of a retry and the loss of the byte.

// File: rtl/ulm_pkg.sv
package ulm_pkg;
  localparam logic [3:0] OFF_RXD  = 4'h0;
  localparam logic [3:0] OFF_TXD  = 4'h4;
  localparam logic [3:0] OFF_STAT = 4'h8;
  localparam int STAT_RXV = 0;
  localparam int STAT_TXF = 3;
  typedef enum logic [2:0] {SQ_POLL, SQ_STAT, SQ_PICK, SQ_RX, SQ_TX} sq_t;
endpackage

// File: rtl/ulm_slot.sv
module ulm_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && !full_q) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (full_q && out_ready) begin
      full_q <= 1'b0;
    end
  end

  assign in_ready  = !full_q;
  assign out_valid = full_q;
  assign out_data  = data_q;
endmodule

// File: rtl/ulm_bus_port.sv
module ulm_bus_port #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wbyte,
  output logic              done,
  output logic              bad,
  output logic [7:0]        rbyte,
  output logic [ADDR_W-1:0] awaddr,
  output logic              awvalid,
  input  logic              awready,
  output logic [DATA_W-1:0] wdata,
  output logic [STRB_W-1:0] wstrb,
  output logic              wvalid,
  input  logic              wready,
  input  logic [1:0]        bresp,
  input  logic              bvalid,
  output logic              bready,
  output logic [ADDR_W-1:0] araddr,
  output logic              arvalid,
  input  logic              arready,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        rresp,
  input  logic              rvalid,
  output logic              rready
);
  logic              aw_v, w_v, wr_act, ar_v, rd_act;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        byte_q;
  logic              b_hs, r_hs;
  logic              unused_rhi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_v <= 1'b0; w_v <= 1'b0; wr_act <= 1'b0;
      ar_v <= 1'b0; rd_act <= 1'b0;
      addr_q <= '0; byte_q <= '0;
    end else if (start) begin
      addr_q <= addr;
      byte_q <= wbyte;
      if (we) begin
        aw_v <= 1'b1; w_v <= 1'b1; wr_act <= 1'b1;
      end else begin
        ar_v <= 1'b1; rd_act <= 1'b1;
      end
    end else begin
      if (aw_v && awready) aw_v <= 1'b0;
      if (w_v && wready)   w_v <= 1'b0;
      if (b_hs)            wr_act <= 1'b0;
      if (ar_v && arready) ar_v <= 1'b0;
      if (r_hs)            rd_act <= 1'b0;
    end
  end

  assign awaddr  = addr_q;
  assign araddr  = addr_q;
  assign awvalid = aw_v;
  assign wvalid  = w_v;
  assign arvalid = ar_v;
  assign wdata   = {{(DATA_W-8){1'b0}}, byte_q};
  assign wstrb   = STRB_W'(1);
  assign bready  = wr_act && !aw_v && !w_v;
  assign rready  = rd_act && !ar_v;
  assign b_hs    = bvalid && bready;
  assign r_hs    = rvalid && rready;
  assign done    = b_hs || r_hs;
  assign bad     = b_hs ? (bresp != 2'b00) : (rresp != 2'b00);
  assign rbyte   = rdata[7:0];
  assign unused_rhi = ^rdata[DATA_W-1:8];
endmodule

// File: rtl/ulm_seq.sv
module ulm_seq
  import ulm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              bad,
  input  logic [7:0]        rbyte,
  input  logic              tx_avail,
  input  logic              rx_space,
  output logic              start,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic              tx_take,
  output logic              rx_push
);
  sq_t  st, nxt;
  logic can_rx, can_tx;

  always_comb begin
    start = 1'b0; we = 1'b0; addr = ADDR_W'(OFF_STAT);
    tx_take = 1'b0; rx_push = 1'b0; nxt = st;
    unique case (st)
      SQ_POLL: begin start = 1'b1; nxt = SQ_STAT; end
      SQ_STAT: if (done) nxt = SQ_PICK;
      SQ_PICK: begin
        if (can_rx && rx_space) begin
          start = 1'b1; addr = ADDR_W'(OFF_RXD); nxt = SQ_RX;
        end else if (can_tx && tx_avail) begin
          start = 1'b1; we = 1'b1; addr = ADDR_W'(OFF_TXD);
          tx_take = 1'b1; nxt = SQ_TX;
        end else begin
          nxt = SQ_POLL;
        end
      end
      SQ_RX: if (done) begin rx_push = !bad; nxt = SQ_POLL; end
      SQ_TX: if (done) nxt = SQ_POLL;
      default: nxt = SQ_POLL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_POLL; can_rx <= 1'b0; can_tx <= 1'b0;
    end else begin
      st <= nxt;
      if (st == SQ_STAT && done) begin
        can_rx <= !bad && rbyte[STAT_RXV];
        can_tx <= !bad && !rbyte[STAT_TXF];
      end
    end
  end
endmodule

// File: rtl/uart_lite_master.sv
module uart_lite_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [7:0]        tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [7:0]        rx_data,
  output logic              err_flag,
  output logic [ADDR_W-1:0] awaddr,
  output logic [2:0]        awprot,
  output logic              awvalid,
  input  logic              awready,
  output logic [DATA_W-1:0] wdata,
  output logic [STRB_W-1:0] wstrb,
  output logic              wvalid,
  input  logic              wready,
  input  logic [1:0]        bresp,
  input  logic              bvalid,
  output logic              bready,
  output logic [ADDR_W-1:0] araddr,
  output logic [2:0]        arprot,
  output logic              arvalid,
  input  logic              arready,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        rresp,
  input  logic              rvalid,
  output logic              rready
);
  logic              start, we, done, bad, tx_take, rx_push, tx_avail, rx_space;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        rbyte, tx_byte;
  logic              err_q;

  ulm_slot #(.W(8)) u_txbuf (
    .clk, .rst_n,
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .out_valid(tx_avail), .out_ready(tx_take), .out_data(tx_byte)
  );

  ulm_slot #(.W(8)) u_rxbuf (
    .clk, .rst_n,
    .in_valid(rx_push), .in_ready(rx_space), .in_data(rbyte),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data)
  );

  ulm_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk, .rst_n, .done, .bad, .rbyte, .tx_avail, .rx_space,
    .start, .we, .addr, .tx_take, .rx_push
  );

  ulm_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk, .rst_n, .start, .we, .addr, .wbyte(tx_byte),
    .done, .bad, .rbyte,
    .awaddr, .awvalid, .awready, .wdata, .wstrb, .wvalid, .wready,
    .bresp, .bvalid, .bready, .araddr, .arvalid, .arready,
    .rdata, .rresp, .rvalid, .rready
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          err_q <= 1'b0;
    else if (done && bad) err_q <= 1'b1;
  end

  assign err_flag = err_q;
  assign awprot   = 3'b000;
  assign arprot   = 3'b000;
endmodule

// File: rtl/ulm_checker.sv
module ulm_checker
  import ulm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              awvalid,
  input logic              awready,
  input logic [ADDR_W-1:0] awaddr,
  input logic              wvalid,
  input logic              wready,
  input logic [DATA_W-1:0] wdata,
  input logic [STRB_W-1:0] wstrb,
  input logic              bvalid,
  input logic              bready,
  input logic [1:0]        bresp,
  input logic              arvalid,
  input logic              arready,
  input logic [ADDR_W-1:0] araddr,
  input logic              rvalid,
  input logic              rready,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        rresp,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [7:0]        rx_data,
  input logic              err_flag
);
  logic [ADDR_W-1:0] ar_q;
  logic ok_rx, ok_tx, rd_open, wr_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar_q <= '0; ok_rx <= 1'b0; ok_tx <= 1'b0; rd_open <= 1'b0; wr_open <= 1'b0;
    end else begin
      if (arvalid && arready) begin ar_q <= araddr; rd_open <= 1'b1; end
      if (awvalid && awready) wr_open <= 1'b1;
      if (rvalid && rready) begin
        rd_open <= 1'b0;
        ok_rx <= (ar_q == ADDR_W'(OFF_STAT)) && (rresp == 2'b00) && rdata[STAT_RXV];
        ok_tx <= (ar_q == ADDR_W'(OFF_STAT)) && (rresp == 2'b00) && !rdata[STAT_TXF];
      end
      if (bvalid && bready) begin
        wr_open <= 1'b0; ok_rx <= 1'b0; ok_tx <= 1'b0;
      end
    end
  end

  a_r2_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid && $stable(awaddr));
  a_r2_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready |=> wvalid && $stable(wdata));
  a_r2_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(awvalid) |-> $rose(wvalid));
  a_r2_single: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(awvalid) |-> !wr_open && !rd_open);
  a_r3_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid && !arready |=> arvalid && $stable(araddr));
  a_r3_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(arvalid && (awvalid || wvalid)));
  a_r3_single: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arvalid) |-> !rd_open && !wr_open);
  a_r4_waddr: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> awaddr == ADDR_W'(OFF_TXD));
  a_r4_raddr: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid |-> (araddr == ADDR_W'(OFF_RXD)) || (araddr == ADDR_W'(OFF_STAT)));
  a_r5_wbeat: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid |-> (wstrb == STRB_W'(1)) && (wdata[DATA_W-1:8] == '0));
  a_r6_tx_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(awvalid) |-> ok_tx);
  a_r7_rx_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arvalid) && (araddr == ADDR_W'(OFF_RXD)) |-> ok_rx && !rx_valid);
  a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));
  a_r10_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((bvalid && bready && bresp != 2'b00) || (rvalid && rready && rresp != 2'b00)) |=> err_flag);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
endmodule

bind uart_lite_master ulm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
  .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
  .bvalid(bvalid), .bready(bready), .bresp(bresp),
  .arvalid(arvalid), .arready(arready), .araddr(araddr),
  .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .err_flag(err_flag)
);

// File: tb/tb_uart_lite_master.sv
module tb_uart_lite_master;
  localparam int CLK_NS = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b0, err_flag;
  logic [7:0] tx_data = '0, rx_data;
  logic [AW-1:0] awaddr, araddr;
  logic [2:0] awprot, arprot;
  logic awvalid, awready, wvalid, wready, bvalid, bready;
  logic arvalid, arready, rvalid, rready;
  logic [DW-1:0] wdata, rdata;
  logic [3:0] wstrb;
  logic [1:0] bresp, rresp;

  uart_lite_master #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

  // peripheral model configuration
  logic [1:0] aw_dly = 0, w_dly = 0, ar_dly = 1;
  logic [1:0] bresp_cfg = 0, rresp_cfg = 0;
  logic full_cfg = 1'b0, push_v = 1'b0;
  logic [7:0] push_b = '0;

  // peripheral model state
  logic [2:0] aw_c, w_c, ar_c;
  logic got_aw, got_w, tx_full_q;
  logic [AW-1:0] aw_q;
  logic [DW-1:0] w_q;
  logic [3:0] s_q;
  logic [7:0] rq [0:7];
  logic [2:0] rq_rp, rq_wp;
  logic [3:0] rq_cnt;
  logic [DW-1:0] tx_log [0:15];
  logic [3:0] strb_log [0:15];
  logic [AW-1:0] addr_log [0:15];
  int wr_cnt, rxrd_cnt, stat_cnt, op_seq, rx_seq, tx_seq, got_cnt;
  logic [7:0] last_got;

  assign awready = awvalid && (aw_c >= 3'(aw_dly));
  assign wready  = wvalid && (w_c >= 3'(w_dly));
  assign arready = arvalid && (ar_c >= 3'(ar_dly));

  always @(posedge clk) begin
    int pop;
    pop = 0;
    aw_c <= (awvalid && !awready) ? aw_c + 1 : 3'd0;
    w_c  <= (wvalid && !wready) ? w_c + 1 : 3'd0;
    ar_c <= (arvalid && !arready) ? ar_c + 1 : 3'd0;
    tx_full_q <= full_cfg;
    if (!rst_n) begin
      got_aw <= 0; got_w <= 0; bvalid <= 0; rvalid <= 0;
    end else begin
      if (awvalid && awready) begin got_aw <= 1; aw_q <= awaddr; end
      if (wvalid && wready) begin got_w <= 1; w_q <= wdata; s_q <= wstrb; end
      if (got_aw && got_w && !bvalid) begin
        bvalid <= 1; bresp <= bresp_cfg; got_aw <= 0; got_w <= 0;
        tx_log[wr_cnt[3:0]] <= w_q; strb_log[wr_cnt[3:0]] <= s_q;
        addr_log[wr_cnt[3:0]] <= aw_q; wr_cnt <= wr_cnt + 1;
      end
      if (bvalid && bready) begin
        bvalid <= 0; op_seq <= op_seq + 1; tx_seq <= op_seq;
      end
      if (arvalid && arready) begin
        rvalid <= 1;
        if (araddr == 32'h0) begin
          rdata <= {24'hC3A5E1, rq[rq_rp]}; rresp <= rresp_cfg;
          rxrd_cnt <= rxrd_cnt + 1;
          if (rq_cnt != 0) begin pop = 1; rq_rp <= rq_rp + 1; end
        end else begin
          rdata <= {28'h0, tx_full_q, 1'b1, 1'b1, rq_cnt != 0}; rresp <= 2'b00;
          stat_cnt <= stat_cnt + 1;
        end
      end
      if (rvalid && rready) begin
        rvalid <= 0; op_seq <= op_seq + 1;
        if (rdata[31:8] == 24'hC3A5E1) rx_seq <= op_seq;
      end
      if (rx_valid && rx_ready) begin got_cnt <= got_cnt + 1; last_got <= rx_data; end
    end
    if (push_v) begin rq[rq_wp] <= push_b; rq_wp <= rq_wp + 1; end
    rq_cnt <= rq_cnt + 4'(push_v) - 4'(pop);
  end

  initial begin
    aw_c = 0; w_c = 0; ar_c = 0; rq_rp = 0; rq_wp = 0; rq_cnt = 0;
    wr_cnt = 0; rxrd_cnt = 0; stat_cnt = 0; op_seq = 1; rx_seq = 0; tx_seq = 0;
    got_cnt = 0; last_got = 0; bresp = 0; rresp = 0; rdata = 0; tx_full_q = 0;
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_tx(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    for (int k = 0; k < 500 && !tx_ready; k++) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk);
    push_v = 1'b1; push_b = b;
    @(negedge clk);
    push_v = 1'b0;
  endtask

  task automatic wait_wr(input int target);
    for (int k = 0; k < 500 && wr_cnt < target; k++) @(negedge clk);
  endtask

  typedef struct packed { logic [7:0] b; logic [1:0] dly; } vec_t;
  localparam vec_t VECS [5] = '{
    '{8'h00, 2'd0}, '{8'hFF, 2'd3}, '{8'h5A, 2'd1}, '{8'h80, 2'd2}, '{8'h01, 2'd0}
  };

  bit done_flag = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int base, sbase;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk(!awvalid && !wvalid && !arvalid, "R1 bus idle in reset", {awvalid, wvalid, arvalid}, 0);
    rst_n = 1'b1;
    chk(tx_ready && !rx_valid && !err_flag, "R1 stream/err after reset",
        {tx_ready, rx_valid, err_flag}, 3'b100);

    // R2 R4 R5 R9: transmit table with varied channel delays
    foreach (VECS[i]) begin
      aw_dly = VECS[i].dly; w_dly = 2'd3 - VECS[i].dly;
      send_tx(VECS[i].b);
      wait_wr(i + 1);
      chk(tx_log[i] == {24'h0, VECS[i].b}, "R5 wdata word", tx_log[i], {24'h0, VECS[i].b});
      chk(strb_log[i] == 4'b0001, "R5 wstrb", strb_log[i], 4'b0001);
      chk(addr_log[i] == 32'h4, "R4 write address", addr_log[i], 32'h4);
    end
    aw_dly = 0; w_dly = 0;

    // R6 R9: transmit gated by FIFO-full status
    full_cfg = 1'b1;
    repeat (4) @(negedge clk);
    base = wr_cnt; sbase = stat_cnt;
    send_tx(8'h77);
    chk(!tx_ready, "R9 tx_ready low while buffered", tx_ready, 0);
    repeat (60) @(negedge clk);
    chk(wr_cnt == base, "R6 no write while full", wr_cnt, base);
    chk(stat_cnt > sbase + 2, "R6 status polled while full", stat_cnt, sbase + 3);
    full_cfg = 1'b0;
    wait_wr(base + 1);
    chk(tx_log[base] == 32'h77, "R6 write after space", tx_log[base], 32'h77);
    @(negedge clk);
    chk(tx_ready, "R9 tx_ready back high", tx_ready, 1);

    // R7 R8: receive holding and back-pressure
    base = rxrd_cnt;
    repeat (30) @(negedge clk);
    chk(rxrd_cnt == base, "R7 no rx read when status empty", rxrd_cnt, base);
    push_rx(8'hA5);
    push_rx(8'h3C);
    for (int k = 0; k < 300 && !rx_valid; k++) @(negedge clk);
    chk(rx_valid && rx_data == 8'hA5, "R8 first rx byte", rx_data, 8'hA5);
    repeat (40) @(negedge clk);
    chk(rxrd_cnt == base + 1, "R7 no fetch while byte waits", rxrd_cnt, base + 1);
    chk(rx_valid && rx_data == 8'hA5, "R8 byte held stable", rx_data, 8'hA5);
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
    for (int k = 0; k < 300 && !rx_valid; k++) @(negedge clk);
    chk(rx_valid && rx_data == 8'h3C, "R8 second rx byte", rx_data, 8'h3C);
    rx_ready = 1'b1;

    // R11: receive served before transmit from one status read
    full_cfg = 1'b1;
    repeat (4) @(negedge clk);
    base = wr_cnt;
    send_tx(8'h42);
    @(negedge clk);
    push_v = 1'b1; push_b = 8'h99; full_cfg = 1'b0;
    @(negedge clk);
    push_v = 1'b0;
    wait_wr(base + 1);
    repeat (10) @(negedge clk);
    chk(rx_seq != 0 && rx_seq < tx_seq, "R11 rx before tx", rx_seq, tx_seq);
    chk(last_got == 8'h99, "R11 rx byte delivered", last_got, 8'h99);

    // R10: write error sticky, not retried
    bresp_cfg = 2'b10;
    base = wr_cnt;
    send_tx(8'h11);
    wait_wr(base + 1);
    repeat (5) @(negedge clk);
    chk(err_flag, "R10 err after bresp", err_flag, 1);
    bresp_cfg = 2'b00;
    repeat (40) @(negedge clk);
    chk(wr_cnt == base + 1, "R10 no write retry", wr_cnt, base + 1);
    send_tx(8'h22);
    wait_wr(base + 2);
    repeat (5) @(negedge clk);
    chk(tx_log[base + 1] == 32'h22, "R10 next write proceeds", tx_log[base + 1], 32'h22);
    chk(err_flag, "R10 err stays set", err_flag, 1);

    // R10: receive error yields no byte
    rresp_cfg = 2'b10;
    base = got_cnt; sbase = rxrd_cnt;
    push_rx(8'h55);
    for (int k = 0; k < 300 && rxrd_cnt == sbase; k++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(got_cnt == base && !rx_valid, "R10 failed rx read gives no byte", got_cnt, base);
    chk(rxrd_cnt == sbase + 1, "R10 no rx read retry", rxrd_cnt, sbase + 1);
    rresp_cfg = 2'b00;

    // R1: reset clears sticky flag
    rst_n = 1'b0;
    @(negedge clk);
    chk(!err_flag && tx_ready && !rx_valid, "R1 reset clears err", err_flag, 0);
    rst_n = 1'b1;

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule